// File: doc/BRIEF.md
# Predicated Four-Lane Vector Execution Unit

This block executes one arithmetic operation across all four 32-bit lanes of a small vector register file. An operation names a destination vector, a first source vector and either a second source vector or a scalar that is broadcast to every lane. It performs wrapping add, wrapping subtract or low-half multiply. A compare-not-equal operation tests each lane of a vector against a scalar and stores the per-lane results in a single mask register. Any arithmetic operation can be flagged as predicated, so that only lanes whose mask bit is set are updated.

The datapath width is a parameter, separate from the vector width. With four execution lanes an operation completes in one pass. With two execution lanes the lower lane pair is handled in the first pass and the upper pair in the second. An issue handshake (valid/ready) accepts one operation at a time, and a one-cycle done pulse marks completion. A preload port fills whole vectors while the unit is idle. A combinational readback port exposes any vector and the mask.

Top module: `vec_pred_unit`

## Requirements
- R1: With iss_scalar_form low, opcode 0 adds, 1 subtracts (A minus B) and 2 multiplies lane i of source A with lane i of source B. Lane i occupies bits 32i+31..32i. Sums and differences wrap modulo 2^32, and a product keeps its low 32 bits.
- R2: With iss_scalar_form high, opcodes 0 to 2 use iss_scalar in place of source B on every lane.
- R3: Opcode 3 sets mask bit i when lane i of source A differs from iss_scalar, and clears it otherwise. All four bits are written even when iss_masked is set, iss_scalar_form is ignored, and no vector register changes.
- R4: With iss_masked set, an arithmetic operation writes only the destination lanes whose mask bit is 1. Every other lane keeps its earlier value.
- R5: With iss_masked clear, an arithmetic operation writes all four destination lanes, whatever the mask holds, including when the destination is also a source.
- R6: An operation is accepted on a rising edge where iss_valid and iss_ready are both high, and iss_ready is low in the following cycle. At full width the result is written on the next edge, and done is high for exactly the one cycle after that edge.
- R7: At half width, lanes 0 and 1 are written on the first edge after acceptance and lanes 2 and 3 on the second. Done is high for the one cycle after the second.
- R8: After a synchronous active-low reset, every vector and the mask read zero, iss_ready is high and done is low.
- R9: iss_valid presented while an operation is in flight is ignored, and that operation is never executed.
- R10: When ld_valid is high on an edge where no operation is in flight, ld_data is written whole into vector ld_idx. ld_valid is ignored while an operation is in flight. rd_vec and mask_out show vector rd_idx and the mask without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Operation offered |
| iss_ready | output | 1 | Unit idle, offer will be taken |
| iss_op | input | 2 | 0 add, 1 subtract, 2 multiply, 3 compare-not-equal |
| iss_scalar_form | input | 1 | Use scalar instead of source B |
| iss_masked | input | 1 | Predicate lanes on the mask |
| iss_dst | input | 3 | Destination vector index |
| iss_src_a | input | 3 | Source A vector index |
| iss_src_b | input | 3 | Source B vector index |
| iss_scalar | input | 32 | Broadcast scalar operand |
| done | output | 1 | One-cycle completion pulse |
| ld_valid | input | 1 | Preload write strobe |
| ld_idx | input | 3 | Preload vector index |
| ld_data | input | 128 | Preload vector, lane 0 in low bits |
| rd_idx | input | 3 | Readback vector index |
| rd_vec | output | 128 | Readback vector contents |
| mask_out | output | 4 | Current mask, bit i for lane i |

## Verification
The embedded properties assume that an operation's latched fields stay fixed from acceptance to completion. They also assume that nothing but the current operation writes the destination during that window, which holds because preloads are gated off while busy. The stimulus keeps the issue and preload inputs stable between falling edges. It drops iss_valid one cycle after acceptance, except in the directed case that deliberately holds a second offer and a preload during the busy cycle to show that both are dropped. The same input sequence drives a full-width and a half-width instance side by side.

// File: rtl/vpu_pkg.sv
// Shared types for the predicated vector unit.
// Assumes a two-bit operation code; the encoding is visible at the top ports.
package vpu_pkg;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_SUB   = 2'd1,
        OP_MUL   = 2'd2,
        OP_CMPNE = 2'd3
    } vop_e;

    // Control fields latched at issue and held for the whole operation.
    typedef struct packed {
        vop_e op;
        logic scal;
        logic masked;
    } vop_ctl_t;

endpackage

// File: rtl/vpu_lane_alu.sv
// One execution lane: wrapping add/subtract, low-half multiply and an
// inequality flag. Purely combinational; the caller picks operands.
module vpu_lane_alu
    import vpu_pkg::*;
#(
    parameter int ELEM_W = 32
) (
    input  vop_e              op_i,
    input  logic [ELEM_W-1:0] a_i,
    input  logic [ELEM_W-1:0] b_i,
    output logic [ELEM_W-1:0] res_o,
    output logic              ne_o
);

    // Arithmetic result; widths truncate to the element size.
    always_comb begin
        unique case (op_i)
            OP_ADD:  res_o = a_i + b_i;
            OP_SUB:  res_o = a_i - b_i;
            OP_MUL:  res_o = a_i * b_i;
            default: res_o = '0;
        endcase
    end

    // Lane inequality feeding the mask.
    assign ne_o = (a_i != b_i);

endmodule

// File: rtl/vpu_seq.sv
// Issue and pass sequencer. Accepts one operation when idle, steps through
// PASSES lane groups (one per cycle) and pulses done after the last one.
// Assumes PASSES >= 1.
module vpu_seq #(
    parameter int PASSES = 1,
    localparam int PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid_i,
    output logic              ready_o,
    output logic              accept_o,
    output logic              busy_o,
    output logic [PASS_W-1:0] pass_o,
    output logic              done_o
);

    logic              busy_q;
    logic [PASS_W-1:0] pass_q;
    logic              done_q;

    assign ready_o  = !busy_q;
    assign accept_o = iss_valid_i && !busy_q;
    assign busy_o   = busy_q;
    assign pass_o   = pass_q;
    assign done_o   = done_q;

    // Track the in-flight operation and the lane group being processed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pass_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                busy_q <= 1'b1;
                pass_q <= '0;
            end else if (busy_q) begin
                if (pass_q == PASS_W'(PASSES - 1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    pass_q <= pass_q + 1'b1;
                end
            end
        end
    end

    p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !ready_o);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o));

    p_pass_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (int'(pass_o) < PASSES));

endmodule

// File: rtl/vpu_regfile.sv
// Vector register file plus the lane mask. Lane-granular writes from the
// datapath, whole-vector preload writes, three vector read ports.
// Assumes the caller never raises a preload and a lane write together.
module vpu_regfile #(
    parameter int ELEM_W    = 32,
    parameter int NUM_LANES = 4,
    parameter int NUM_VREGS = 8,
    localparam int VEC_W    = ELEM_W * NUM_LANES,
    localparam int IDX_W    = $clog2(NUM_VREGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     w_idx_i,
    input  logic [NUM_LANES-1:0] we_lane_i,
    input  logic [VEC_W-1:0]     w_data_i,
    input  logic                 ld_we_i,
    input  logic [IDX_W-1:0]     ld_idx_i,
    input  logic [VEC_W-1:0]     ld_data_i,
    input  logic [NUM_LANES-1:0] mask_we_i,
    input  logic [NUM_LANES-1:0] mask_d_i,
    input  logic [IDX_W-1:0]     ra_idx_i,
    input  logic [IDX_W-1:0]     rb_idx_i,
    input  logic [IDX_W-1:0]     rd_idx_i,
    output logic [VEC_W-1:0]     ra_data_o,
    output logic [VEC_W-1:0]     rb_data_o,
    output logic [VEC_W-1:0]     rd_data_o,
    output logic [NUM_LANES-1:0] mask_o
);

    logic [VEC_W-1:0]     vregs [NUM_VREGS];
    logic [NUM_LANES-1:0] mask_q;

    // Update vectors (preload or per-lane result) and mask bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_VREGS; r++) vregs[r] <= '0;
            mask_q <= '0;
        end else begin
            for (int r = 0; r < NUM_VREGS; r++) begin
                if (ld_we_i && ld_idx_i == IDX_W'(r)) begin
                    vregs[r] <= ld_data_i;
                end else if (w_idx_i == IDX_W'(r)) begin
                    for (int l = 0; l < NUM_LANES; l++) begin
                        if (we_lane_i[l])
                            vregs[r][l*ELEM_W +: ELEM_W] <= w_data_i[l*ELEM_W +: ELEM_W];
                    end
                end
            end
            for (int l = 0; l < NUM_LANES; l++) begin
                if (mask_we_i[l]) mask_q[l] <= mask_d_i[l];
            end
        end
    end

    // Asynchronous read ports.
    assign ra_data_o = vregs[ra_idx_i];
    assign rb_data_o = vregs[rb_idx_i];
    assign rd_data_o = vregs[rd_idx_i];
    assign mask_o    = mask_q;

    p_ld_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we_i |-> (we_lane_i == '0 && mask_we_i == '0));

endmodule

// File: rtl/vec_pred_unit.sv
// Predicated vector execution unit. Latches an operation at issue, feeds
// EXEC_LANES copies of the lane ALU from the selected lane group each
// pass, and writes results (or mask bits) lane by lane.
// Assumes EXEC_LANES divides NUM_LANES.
module vec_pred_unit
    import vpu_pkg::*;
#(
    parameter int ELEM_W     = 32,
    parameter int NUM_LANES  = 4,
    parameter int EXEC_LANES = 4,
    parameter int NUM_VREGS  = 8,
    localparam int VEC_W     = ELEM_W * NUM_LANES,
    localparam int IDX_W     = $clog2(NUM_VREGS),
    localparam int PASSES    = NUM_LANES / EXEC_LANES,
    localparam int PASS_W    = (PASSES > 1) ? $clog2(PASSES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_valid,
    output logic                 iss_ready,
    input  logic [1:0]           iss_op,
    input  logic                 iss_scalar_form,
    input  logic                 iss_masked,
    input  logic [IDX_W-1:0]     iss_dst,
    input  logic [IDX_W-1:0]     iss_src_a,
    input  logic [IDX_W-1:0]     iss_src_b,
    input  logic [ELEM_W-1:0]    iss_scalar,
    output logic                 done,
    input  logic                 ld_valid,
    input  logic [IDX_W-1:0]     ld_idx,
    input  logic [VEC_W-1:0]     ld_data,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [VEC_W-1:0]     rd_vec,
    output logic [NUM_LANES-1:0] mask_out
);

    logic              accept;
    logic              busy;
    logic [PASS_W-1:0] pass_idx;

    vop_ctl_t          ctl_q;
    logic [IDX_W-1:0]  dst_q;
    logic [IDX_W-1:0]  src_a_q;
    logic [IDX_W-1:0]  src_b_q;
    logic [ELEM_W-1:0] scalar_q;

    logic [VEC_W-1:0]     ra_vec;
    logic [VEC_W-1:0]     rb_vec;
    logic [VEC_W-1:0]     dst_vec;
    logic [NUM_LANES-1:0] mask_q;

    logic [ELEM_W-1:0] lane_a   [EXEC_LANES];
    logic [ELEM_W-1:0] lane_b   [EXEC_LANES];
    logic [ELEM_W-1:0] lane_res [EXEC_LANES];
    logic              lane_ne  [EXEC_LANES];

    logic [NUM_LANES-1:0] we_lane;
    logic [NUM_LANES-1:0] mask_we;
    logic [NUM_LANES-1:0] mask_d;
    logic [VEC_W-1:0]     w_vec;
    logic                 ld_we;

    vpu_seq #(.PASSES(PASSES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .iss_valid_i (iss_valid),
        .ready_o     (iss_ready),
        .accept_o    (accept),
        .busy_o      (busy),
        .pass_o      (pass_idx),
        .done_o      (done)
    );

    // Capture the operation fields when the issue is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '{op: OP_ADD, scal: 1'b0, masked: 1'b0};
            dst_q    <= '0;
            src_a_q  <= '0;
            src_b_q  <= '0;
            scalar_q <= '0;
        end else if (accept) begin
            ctl_q    <= '{op: vop_e'(iss_op), scal: iss_scalar_form, masked: iss_masked};
            dst_q    <= iss_dst;
            src_a_q  <= iss_src_a;
            src_b_q  <= iss_src_b;
            scalar_q <= iss_scalar;
        end
    end

    // Select the operands of the current lane group; compare always uses the scalar.
    always_comb begin
        for (int k = 0; k < EXEC_LANES; k++) begin
            lane_a[k] = ra_vec[(int'(pass_idx) * EXEC_LANES + k) * ELEM_W +: ELEM_W];
            if (ctl_q.scal || ctl_q.op == OP_CMPNE)
                lane_b[k] = scalar_q;
            else
                lane_b[k] = rb_vec[(int'(pass_idx) * EXEC_LANES + k) * ELEM_W +: ELEM_W];
        end
    end

    for (genvar k = 0; k < EXEC_LANES; k++) begin : g_alu
        vpu_lane_alu #(.ELEM_W(ELEM_W)) u_alu (
            .op_i  (ctl_q.op),
            .a_i   (lane_a[k]),
            .b_i   (lane_b[k]),
            .res_o (lane_res[k]),
            .ne_o  (lane_ne[k])
        );
    end

    // Map ALU outputs onto architectural lanes and form the write enables.
    always_comb begin
        for (int g = 0; g < NUM_LANES; g++) begin
            logic in_pass;
            in_pass    = busy && ((g / EXEC_LANES) == int'(pass_idx));
            we_lane[g] = in_pass && (ctl_q.op != OP_CMPNE) && (!ctl_q.masked || mask_q[g]);
            mask_we[g] = in_pass && (ctl_q.op == OP_CMPNE);
            mask_d[g]  = lane_ne[g % EXEC_LANES];
            w_vec[g*ELEM_W +: ELEM_W] = lane_res[g % EXEC_LANES];
        end
    end

    // Preloads are refused while an operation owns the register file.
    assign ld_we = ld_valid && !busy;

    vpu_regfile #(
        .ELEM_W    (ELEM_W),
        .NUM_LANES (NUM_LANES),
        .NUM_VREGS (NUM_VREGS)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .w_idx_i   (dst_q),
        .we_lane_i (we_lane),
        .w_data_i  (w_vec),
        .ld_we_i   (ld_we),
        .ld_idx_i  (ld_idx),
        .ld_data_i (ld_data),
        .mask_we_i (mask_we),
        .mask_d_i  (mask_d),
        .ra_idx_i  (src_a_q),
        .rb_idx_i  (src_b_q),
        .rd_idx_i  (dst_q),
        .ra_data_o (ra_vec),
        .rb_data_o (rb_vec),
        .rd_data_o (dst_vec),
        .mask_o    (mask_q)
    );

    // Second read path for the external readback port.
    vpu_regfile_peek #(
        .VEC_W (VEC_W),
        .IDX_W (IDX_W)
    ) u_peek (
        .sel_i  (rd_idx),
        .mask_i (mask_q),
        .mask_o (mask_out)
    );

    // Readback vector comes from an indexed view of the register file.
    assign rd_vec = u_rf.vregs[rd_idx];

    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && ctl_q.op == OP_CMPNE) |=> $stable(mask_out));

    p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !accept) |=> ($stable(dst_q) && $stable(ctl_q) && $stable(scalar_q)));

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_hold
        p_masked_lane_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && ctl_q.masked && ctl_q.op != OP_CMPNE && !mask_q[g])
            |=> $stable(dst_vec[g*ELEM_W +: ELEM_W]));
    end

endmodule

// File: rtl/vpu_regfile_peek.sv
// Pass-through of the mask to the readback side. Kept as its own module so
// the readback path can later gain a pipeline stage without touching the core.
module vpu_regfile_peek #(
    parameter int VEC_W = 128,
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] sel_i,
    input  logic [3:0]       mask_i,
    output logic [3:0]       mask_o
);

    logic unused_sel;

    // Mask is forwarded as is; the index is only needed by the vector path.
    assign mask_o     = mask_i;
    assign unused_sel = ^{sel_i, VEC_W[0]};

endmodule

// File: tb/vec_pred_unit_tb.sv
// Bench: a full-width and a half-width instance share every input; a
// bench-side model of the requirements gives the expected registers.
module vec_pred_unit_tb;

    localparam real TCLK = 20.0;

    typedef struct packed {
        logic [1:0]  op;
        logic        sc;
        logic        mk;
        logic [2:0]  dst;
        logic [2:0]  a;
        logic [2:0]  b;
        logic [31:0] s;
    } stim_t;

    localparam int NSTIM = 15;
    localparam stim_t TBL [NSTIM] = '{
        '{op:2'd0, sc:1'b0, mk:1'b0, dst:3'd4, a:3'd1, b:3'd2, s:32'd0},
        '{op:2'd1, sc:1'b0, mk:1'b0, dst:3'd5, a:3'd3, b:3'd2, s:32'd0},
        '{op:2'd2, sc:1'b0, mk:1'b0, dst:3'd6, a:3'd1, b:3'd2, s:32'd0},
        '{op:2'd0, sc:1'b1, mk:1'b0, dst:3'd7, a:3'd2, b:3'd0, s:32'd1},
        '{op:2'd1, sc:1'b1, mk:1'b0, dst:3'd4, a:3'd1, b:3'd0, s:32'd3},
        '{op:2'd2, sc:1'b1, mk:1'b0, dst:3'd5, a:3'd2, b:3'd0, s:32'h0001_0000},
        '{op:2'd3, sc:1'b1, mk:1'b0, dst:3'd0, a:3'd1, b:3'd0, s:32'd2},
        '{op:2'd0, sc:1'b0, mk:1'b1, dst:3'd6, a:3'd1, b:3'd3, s:32'd0},
        '{op:2'd2, sc:1'b1, mk:1'b1, dst:3'd7, a:3'd2, b:3'd0, s:32'hffff_fffe},
        '{op:2'd1, sc:1'b0, mk:1'b0, dst:3'd1, a:3'd1, b:3'd3, s:32'd0},
        '{op:2'd3, sc:1'b1, mk:1'b1, dst:3'd0, a:3'd0, b:3'd0, s:32'd0},
        '{op:2'd0, sc:1'b1, mk:1'b1, dst:3'd4, a:3'd2, b:3'd0, s:32'd9},
        '{op:2'd3, sc:1'b1, mk:1'b0, dst:3'd0, a:3'd3, b:3'd0, s:32'd0},
        '{op:2'd1, sc:1'b1, mk:1'b1, dst:3'd3, a:3'd3, b:3'd0, s:32'd1},
        '{op:2'd3, sc:1'b0, mk:1'b0, dst:3'd0, a:3'd2, b:3'd1, s:32'd10}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         iss_valid = 1'b0;
    logic [1:0]   iss_op = '0;
    logic         iss_scalar_form = 1'b0;
    logic         iss_masked = 1'b0;
    logic [2:0]   iss_dst = '0;
    logic [2:0]   iss_src_a = '0;
    logic [2:0]   iss_src_b = '0;
    logic [31:0]  iss_scalar = '0;
    logic         ld_valid = 1'b0;
    logic [2:0]   ld_idx = '0;
    logic [127:0] ld_data = '0;
    logic [2:0]   rd_idx = '0;

    logic         rdy_f, rdy_h, done_f, done_h;
    logic [127:0] vec_f, vec_h;
    logic [3:0]   msk_f, msk_h;

    logic [127:0] mv [8];
    logic [3:0]   mm;

    int n_checks = 0;
    int n_fail   = 0;

    always #(TCLK / 2.0) clk = ~clk;

    vec_pred_unit #(.EXEC_LANES(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(rdy_f),
        .iss_op(iss_op), .iss_scalar_form(iss_scalar_form), .iss_masked(iss_masked),
        .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .iss_scalar(iss_scalar), .done(done_f), .ld_valid(ld_valid), .ld_idx(ld_idx),
        .ld_data(ld_data), .rd_idx(rd_idx), .rd_vec(vec_f), .mask_out(msk_f)
    );

    vec_pred_unit #(.EXEC_LANES(2)) u_half (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(rdy_h),
        .iss_op(iss_op), .iss_scalar_form(iss_scalar_form), .iss_masked(iss_masked),
        .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .iss_scalar(iss_scalar), .done(done_h), .ld_valid(ld_valid), .ld_idx(ld_idx),
        .ld_data(ld_data), .rd_idx(rd_idx), .rd_vec(vec_h), .mask_out(msk_h)
    );

    task automatic chk(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input stim_t s);
        if (s.op == 2'd3) return "R3";
        if (s.mk)         return "R4";
        if (s.sc)         return "R2,R5";
        return "R1,R5";
    endfunction

    // Apply one operation to the bench model, following the requirements.
    function automatic void model_apply(input stim_t s);
        logic [127:0] nv;
        logic [3:0]   nm;
        nv = mv[s.dst];
        nm = mm;
        for (int l = 0; l < 4; l++) begin
            logic [31:0] a, b, r;
            a = mv[s.a][l*32 +: 32];
            b = (s.sc || s.op == 2'd3) ? s.s : mv[s.b][l*32 +: 32];
            case (s.op)
                2'd0:    r = a + b;
                2'd1:    r = a - b;
                default: r = a * b;
            endcase
            if (s.op == 2'd3) nm[l] = (a != b);
            else if (!s.mk || mm[l]) nv[l*32 +: 32] = r;
        end
        mv[s.dst] = nv;
        mm = nm;
    endfunction

    task automatic preload(input logic [2:0] idx, input logic [127:0] data);
        @(negedge clk);
        ld_valid = 1'b1; ld_idx = idx; ld_data = data;
        @(negedge clk);
        ld_valid = 1'b0;
        mv[idx] = data;
        rd_idx = idx;
        #1;
        chk("R10", "preload readback full", vec_f, data);
        chk("R10", "preload readback half", vec_h, data);
    endtask

    task automatic drive_op(input stim_t s);
        iss_op = s.op; iss_scalar_form = s.sc; iss_masked = s.mk;
        iss_dst = s.dst; iss_src_a = s.a; iss_src_b = s.b; iss_scalar = s.s;
    endtask

    // Issue one operation to both instances and check timing and results.
    task automatic run_op(input stim_t s);
        logic [127:0] old_v, new_v;
        logic [3:0]   old_m, new_m;
        int lf, lh;
        string tg;
        tg = tag_of(s);
        old_v = mv[s.dst]; old_m = mm;
        model_apply(s);
        new_v = mv[s.dst]; new_m = mm;
        @(negedge clk);
        drive_op(s);
        iss_valid = 1'b1;
        @(negedge clk);
        iss_valid = 1'b0;
        rd_idx = s.dst;
        #1;
        chk("R6", "ready low after accept", {126'd0, rdy_f, rdy_h}, 128'd0);
        lf = -1; lh = -1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            #1;
            if (done_f && lf < 0) lf = k;
            if (done_h && lh < 0) lh = k;
            if (k == 1) begin
                chk("R7", "half width after first pass vec", vec_h,
                    {old_v[127:64], new_v[63:0]});
                chk("R7", "half width after first pass mask", {124'd0, msk_h},
                    {124'd0, old_m[3:2], new_m[1:0]});
            end
        end
        chk("R6", "full width done latency", 128'(lf), 128'd1);
        chk("R7", "half width done latency", 128'(lh), 128'd2);
        chk(tg, "full width dst", vec_f, new_v);
        chk(tg, "half width dst", vec_h, new_v);
        chk(tg, "full width mask", {124'd0, msk_f}, {124'd0, new_m});
        chk(tg, "half width mask", {124'd0, msk_h}, {124'd0, new_m});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        for (int r = 0; r < 8; r++) mv[r] = '0;
        mm = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R8: reset state of both instances.
        for (int r = 0; r < 8; r++) begin
            rd_idx = 3'(r);
            #1;
            chk("R8", "reset vector full", vec_f, 128'd0);
            chk("R8", "reset vector half", vec_h, 128'd0);
        end
        chk("R8", "reset mask/ready/done",
            {120'd0, msk_f, msk_h}, 128'd0);
        chk("R8", "reset ready high done low",
            {124'd0, rdy_f, rdy_h, done_f, done_h}, {124'd0, 4'b1100});

        // R10: operand preloads.
        preload(3'd1, {32'h4000_0000, 32'd2, 32'd7, 32'd2});
        preload(3'd2, {32'h7fff_ffff, 32'hffff_ffff, 32'd10, 32'd3});
        preload(3'd3, {32'd5, 32'd6, 32'd7, 32'd8});

        // Table walk: R1 to R7 under varied operands, masks and forms.
        for (int i = 0; i < NSTIM; i++) run_op(TBL[i]);

        // R9 and R10: a second offer and a preload during the busy cycle.
        begin
            stim_t sa, sb;
            sa = '{op:2'd0, sc:1'b1, mk:1'b0, dst:3'd7, a:3'd2, b:3'd0, s:32'h55};
            sb = '{op:2'd0, sc:1'b1, mk:1'b0, dst:3'd6, a:3'd2, b:3'd0, s:32'h1234};
            model_apply(sa);
            @(negedge clk);
            drive_op(sa);
            iss_valid = 1'b1;
            @(negedge clk);
            drive_op(sb);
            ld_valid = 1'b1; ld_idx = 3'd5; ld_data = {4{32'hdead_beef}};
            @(negedge clk);
            iss_valid = 1'b0;
            ld_valid = 1'b0;
            repeat (4) @(negedge clk);
            rd_idx = 3'd7; #1;
            chk("R6", "first op result full", vec_f, mv[7]);
            chk("R7", "first op result half", vec_h, mv[7]);
            rd_idx = 3'd6; #1;
            chk("R9", "busy offer ignored full", vec_f, mv[6]);
            chk("R9", "busy offer ignored half", vec_h, mv[6]);
            rd_idx = 3'd5; #1;
            chk("R10", "busy preload ignored full", vec_f, mv[5]);
            chk("R10", "busy preload ignored half", vec_h, mv[5]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule